// File: doc/BRIEF.md
# Serial Output-Driver Program-and-Verify Sequencer

This block is a master-side controller for an eight-channel serial low-side output driver. A single `start` pulse and a command byte set off a complete program-and-verify cycle. The block sends the byte over a four-wire serial link. It then keeps chip-enable high for a settle interval, so that the driver's turn-on protection window can close. After that it sends the same byte a second time. While the second frame is shifted out, it collects the diagnostic byte that the driver returns.

A command bit of 0 turns a channel on and a bit of 1 turns it off. The returned bit reports the level on each output pin. A channel whose returned bit differs from its command bit is reported as faulty. Each faulty channel is then classed as a short or overload when it was commanded on, and as an open load when it was commanded off. The result stays on the outputs while `done` is high.

The serial clock rate, the chip-enable lead and lag times and the settle interval are parameters counted in system clock cycles. This lets one design meet the driver's timing limits at any system clock rate.

Top module: `spi_diag_seq`

## Requirements
- R1: After reset, `ce_n` is 1, `sclk` is 0, `busy` and `done` are 0, and `fault_mask` and `fault_short` are all zeros.
- R2: A `start` pulse while idle captures `cmd`, raises `busy` on the next clock edge and clears `done`. `start` pulses and `cmd` changes while `busy` is high have no effect on the bytes sent or on the result.
- R3: Each frame carries exactly NBITS bits on `si`, most significant bit first, and every frame equals the captured command. `si` changes only at the falling edge of `ce_n` or while `sclk` is high, so it is stable across every falling `sclk` edge.
- R4: `sclk` is 0 whenever `ce_n` is 1 and at every `ce_n` transition. Each high phase and each low phase between bits lasts at least HALF_CYC clock cycles.
- R5: At least LEAD_CYC clock cycles pass from the fall of `ce_n` to the first rising `sclk` edge. At least LAG_CYC cycles pass from the last falling `sclk` edge to the rise of `ce_n`.
- R6: One run produces exactly two frames. `ce_n` stays high for at least SETTLE_CYC clock cycles between the end of the first frame and the start of the second.
- R7: During the second frame, `so` is sampled at each falling `sclk` edge. Bit i of `fault_mask` is 1 exactly when the returned bit i differs from command bit i.
- R8: Bit i of `fault_short` is 1 only for a faulty channel with command bit 0 (on, pin read high). It is 0 for an open-load fault (command bit 1, pin read low) and for every channel that is not faulty.
- R9: At the rise of `ce_n` that ends the second frame, `busy` falls and `done` rises on the same clock edge. `done`, `fault_mask` and `fault_short` then hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| cmd | input | NBITS | Command byte; 0 = channel on, 1 = channel off |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Result valid, held until the next start |
| fault_mask | output | NBITS | 1 = channel returned a level different from its command |
| fault_short | output | NBITS | 1 = short or overload; 0 = open load or no fault |
| ce_n | output | 1 | Chip enable to the driver, active low |
| sclk | output | 1 | Serial clock to the driver, idles low |
| si | output | 1 | Serial data to the driver |
| so | input | 1 | Diagnostic serial data from the driver |

## Verification
A behavioural model of the driver returns, for each channel, its latched command bit XOR an injected fault bit. The result therefore separates healthy channels, shorted channels (commanded on but reading high) and open channels (commanded off but reading low). Directed patterns cover several cases: all channels on with every channel shorted, all channels off with every channel open, alternating commands with no faults, and mixed half-faulted bytes. These show whether short and open are told apart correctly, and whether the bit order is reversed. Random command and fault bytes exercise mixed cases. One run pulses `start` with a different `cmd` in the middle of the run; this shows whether the captured byte is protected. Timing monitors measure the lead, lag, phase and settle intervals, and check the `sclk` level at every chip-enable edge.

// File: rtl/spi_diag_pkg.sv
`timescale 1ns/1ps
package spi_diag_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_LAG,
        PH_SETTLE
    } phase_e;

endpackage

// File: rtl/spi_diag_timer.sv
`timescale 1ns/1ps
module spi_diag_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_diag_shifter.sv
`timescale 1ns/1ps
module spi_diag_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    input  logic         cap,
    input  logic         cap_bit,
    output logic         ser_out,
    output logic [W-1:0] rx
);

    logic [W-1:0] tx_d, tx_q;
    logic [W-1:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load) begin
            tx_d = load_val;
        end else if (adv) begin
            tx_d = {tx_q[W-2:0], 1'b0};
        end
        if (cap) begin
            rx_d = {rx_q[W-2:0], cap_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign ser_out = tx_q[W-1];
    assign rx      = rx_q;

endmodule

// File: rtl/spi_diag_classify.sv
`timescale 1ns/1ps
module spi_diag_classify #(
    parameter int W = 8
) (
    input  logic [W-1:0] sent,
    input  logic [W-1:0] echoed,
    output logic [W-1:0] mismatch,
    output logic [W-1:0] is_short
);

    for (genvar g = 0; g < W; g++) begin : g_chan
        always_comb begin
            mismatch[g] = sent[g] ^ echoed[g];
            is_short[g] = mismatch[g] & ~sent[g];
        end
    end

endmodule

// File: rtl/spi_diag_seq.sv
`timescale 1ns/1ps
module spi_diag_seq
    import spi_diag_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int HALF_CYC   = 13,
    parameter int LEAD_CYC   = 13,
    parameter int LAG_CYC    = 13,
    parameter int SETTLE_CYC = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] cmd,
    output logic             busy,
    output logic             done,
    output logic [NBITS-1:0] fault_mask,
    output logic [NBITS-1:0] fault_short,
    output logic             ce_n,
    output logic             sclk,
    output logic             si,
    input  logic             so
);

    localparam int MAX_A = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
    localparam int MAX_B = (LAG_CYC > SETTLE_CYC) ? LAG_CYC : SETTLE_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAX_C + 1);
    localparam int BW    = $clog2(NBITS + 1);

    localparam logic [TW-1:0] T_HALF   = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] T_LEAD   = TW'(LEAD_CYC - 1);
    localparam logic [TW-1:0] T_LAG    = TW'(LAG_CYC - 1);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(NBITS);

    typedef struct packed {
        phase_e           phase;
        logic             second;
        logic [BW-1:0]    nbit;
        logic             ce_n;
        logic             sclk;
        logic             busy;
        logic             done;
        logic [NBITS-1:0] cmd;
        logic [NBITS-1:0] mask;
        logic [NBITS-1:0] shrt;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        phase:  PH_IDLE,
        second: 1'b0,
        nbit:   '0,
        ce_n:   1'b1,
        sclk:   1'b0,
        busy:   1'b0,
        done:   1'b0,
        cmd:    '0,
        mask:   '0,
        shrt:   '0
    };

    seq_t s_d, s_q;

    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_exp;
    logic             sh_load;
    logic [NBITS-1:0] sh_val;
    logic             sh_adv;
    logic             sh_cap;
    logic [NBITS-1:0] rx_byte;
    logic [NBITS-1:0] cls_mask;
    logic [NBITS-1:0] cls_short;

    spi_diag_timer #(.TW(TW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    spi_diag_shifter #(.W(NBITS)) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .adv      (sh_adv),
        .cap      (sh_cap),
        .cap_bit  (so),
        .ser_out  (si),
        .rx       (rx_byte)
    );

    spi_diag_classify #(.W(NBITS)) cls_i (
        .sent     (s_q.cmd),
        .echoed   (rx_byte),
        .mismatch (cls_mask),
        .is_short (cls_short)
    );

    // Next-state computation for the whole sequencer
    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        sh_cap   = 1'b0;
        sh_val   = (s_q.phase == PH_IDLE) ? cmd : s_q.cmd;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase  = PH_LEAD;
                    s_d.second = 1'b0;
                    s_d.nbit   = '0;
                    s_d.ce_n   = 1'b0;
                    s_d.busy   = 1'b1;
                    s_d.done   = 1'b0;
                    s_d.cmd    = cmd;
                    sh_load    = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = T_LEAD;
                end
            end
            PH_LEAD: begin
                if (tmr_exp) begin
                    s_d.phase = PH_HIGH;
                    s_d.sclk  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = T_HALF;
                end
            end
            PH_HIGH: begin
                // falling edge: slave latches si, master samples so
                if (tmr_exp) begin
                    s_d.phase = PH_LOW;
                    s_d.sclk  = 1'b0;
                    s_d.nbit  = s_q.nbit + BW'(1);
                    sh_cap    = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = T_HALF;
                end
            end
            PH_LOW: begin
                if (tmr_exp) begin
                    if (s_q.nbit == LAST_BIT) begin
                        s_d.phase = PH_LAG;
                        tmr_load  = 1'b1;
                        tmr_val   = T_LAG;
                    end else begin
                        // rising edge: next data bit goes out with it
                        s_d.phase = PH_HIGH;
                        s_d.sclk  = 1'b1;
                        sh_adv    = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = T_HALF;
                    end
                end
            end
            PH_LAG: begin
                if (tmr_exp) begin
                    s_d.ce_n = 1'b1;
                    if (!s_q.second) begin
                        s_d.phase = PH_SETTLE;
                        tmr_load  = 1'b1;
                        tmr_val   = T_SETTLE;
                    end else begin
                        s_d.phase = PH_IDLE;
                        s_d.busy  = 1'b0;
                        s_d.done  = 1'b1;
                        s_d.mask  = cls_mask;
                        s_d.shrt  = cls_short;
                    end
                end
            end
            PH_SETTLE: begin
                if (tmr_exp) begin
                    s_d.phase  = PH_LEAD;
                    s_d.second = 1'b1;
                    s_d.nbit   = '0;
                    s_d.ce_n   = 1'b0;
                    sh_load    = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = T_LEAD;
                end
            end
            default: begin
                s_d = SEQ_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = s_q.busy;
    assign done        = s_q.done;
    assign fault_mask  = s_q.mask;
    assign fault_short = s_q.shrt;
    assign ce_n        = s_q.ce_n;
    assign sclk        = s_q.sclk;

endmodule

// File: rtl/spi_diag_seq_chk.sv
`timescale 1ns/1ps
module spi_diag_seq_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [NBITS-1:0] fault_mask,
    input logic [NBITS-1:0] fault_short,
    input logic             ce_n,
    input logic             sclk,
    input logic             si
);

    AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ce_n); // R1

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done)); // R2

    AST_SI_HELD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $stable(si)); // R3

    AST_SCLK_LOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !sclk); // R4

    AST_CE_EDGE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n != $past(ce_n)) |-> (!sclk && !$past(sclk))); // R4

    AST_SHORT_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((fault_short & ~fault_mask) == '0)); // R8

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(fault_mask) && $stable(fault_short))); // R9

endmodule

bind spi_diag_seq spi_diag_seq_chk #(.NBITS(NBITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fault_mask  (fault_mask),
    .fault_short (fault_short),
    .ce_n        (ce_n),
    .sclk        (sclk),
    .si          (si)
);

// File: tb/spi_diag_seq_tb_top.sv
`timescale 1ns/1ps
module spi_diag_seq_tb_top;

    localparam int NB   = 8;
    localparam int HC   = 3;
    localparam int LC   = 4;
    localparam int GC   = 5;
    localparam int SC   = 120;
    localparam int TCK  = 20;

    logic          clk;
    logic          rst_n;
    logic          start;
    logic [NB-1:0] cmd;
    logic          busy;
    logic          done;
    logic [NB-1:0] fault_mask;
    logic [NB-1:0] fault_short;
    logic          ce_n;
    logic          sclk;
    logic          si;
    logic          so;

    int total = 0;
    int bad   = 0;

    spi_diag_seq #(
        .NBITS(NB), .HALF_CYC(HC), .LEAD_CYC(LC), .LAG_CYC(GC), .SETTLE_CYC(SC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .busy(busy), .done(done), .fault_mask(fault_mask), .fault_short(fault_short),
        .ce_n(ce_n), .sclk(sclk), .si(si), .so(so)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Driver model: pin level = latched bit XOR injected fault
    logic [NB-1:0] latch_q = '1;
    logic [NB-1:0] inj     = '0;
    logic [NB-1:0] sr      = '0;
    logic [NB-1:0] rxf     = '0;
    logic [NB-1:0] exp_cmd = '0;
    logic          so_r    = 1'b0;
    int  nbits = 0, frames = 0, frame_bad = 0;
    int  v_lead = 0, v_lag = 0, v_high = 0, v_low = 0, v_gap = 0, v_ceclk = 0, v_si = 0;
    bit  first_edge = 1'b0;
    time t_cef = 0, t_cer = 0, t_rise = 0, t_fall = 0;

    assign so = ce_n ? 1'b0 : so_r;

    always @(negedge ce_n) if (rst_n) begin
        if (sclk) v_ceclk++;
        if (frames == 1 && ($time - t_cer) < SC * TCK) v_gap++;
        sr         = latch_q ^ inj;
        nbits      = 0;
        rxf        = '0;
        t_cef      = $time;
        first_edge = 1'b1;
    end

    always @(posedge ce_n) if (rst_n) begin
        if (sclk) v_ceclk++;
        if (($time - t_fall) < GC * TCK) v_lag++;
        latch_q = sr;
        if (nbits != NB || rxf != exp_cmd) frame_bad++;
        frames++;
        t_cer = $time;
    end

    always @(posedge sclk) if (!ce_n) begin
        if (first_edge) begin
            if (($time - t_cef) < LC * TCK) v_lead++;
            first_edge = 1'b0;
        end else if (($time - t_fall) < HC * TCK) begin
            v_low++;
        end
        so_r   = sr[NB-1];
        t_rise = $time;
    end

    always @(negedge sclk) if (!ce_n) begin
        if (($time - t_rise) < HC * TCK) v_high++;
        sr     = {sr[NB-2:0], si};
        rxf    = {rxf[NB-2:0], si};
        nbits++;
        t_fall = $time;
    end

    always @(si) if (rst_n) begin
        #1;
        if (!ce_n && !sclk && ($time - 1) != t_cef) v_si++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] exp_short(input logic [NB-1:0] c, input logic [NB-1:0] f);
        return f & ~c;
    endfunction

    task automatic run(input logic [NB-1:0] c, input logic [NB-1:0] f, input bit meddle);
        exp_cmd = c; inj = f;
        frames = 0; frame_bad = 0;
        v_lead = 0; v_lag = 0; v_high = 0; v_low = 0; v_gap = 0; v_ceclk = 0; v_si = 0;
        @(negedge clk); start = 1'b1; cmd = c;
        @(negedge clk); start = 1'b0; cmd = ~c;
        check(busy === 1'b1, "R2 busy after start", 32'(busy), 1);
        check(done === 1'b0, "R9 done cleared by start", 32'(done), 0);
        if (meddle) begin
            repeat (30) @(negedge clk);
            start = 1'b1; cmd = ~c;
            @(negedge clk); start = 1'b0;
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(frames == 2, "R6 frame count", 32'(frames), 2);
        check(frame_bad == 0, "R3 frame content", 32'(frame_bad), 0);
        check(v_si == 0, "R3 si change while sclk low", 32'(v_si), 0);
        check(v_high == 0 && v_low == 0, "R4 sclk phase width", 32'(v_high + v_low), 0);
        check(v_ceclk == 0, "R4 sclk low at ce edges", 32'(v_ceclk), 0);
        check(v_lead == 0 && v_lag == 0, "R5 lead/lag", 32'(v_lead + v_lag), 0);
        check(v_gap == 0, "R6 settle gap", 32'(v_gap), 0);
        check(fault_mask === f, "R7 fault mask", 32'(fault_mask), 32'(f));
        check(fault_short === exp_short(c, f), "R8 fault type", 32'(fault_short), 32'(exp_short(c, f)));
        check(busy === 1'b0 && ce_n === 1'b1, "R9 busy dropped", 32'(busy), 0);
        repeat (5) @(negedge clk);
        check(done === 1'b1 && fault_mask === f && fault_short === exp_short(c, f),
              "R9 result held", 32'(fault_mask), 32'(f));
    endtask

    initial begin
        int unused_seed;
        rst_n = 1'b0; start = 1'b0; cmd = '0;
        unused_seed = $urandom(32'h5eed);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ce_n === 1'b1 && sclk === 1'b0, "R1 idle lines", {30'd0, ce_n, sclk}, 2);
        check(busy === 1'b0 && done === 1'b0, "R1 flags", {30'd0, busy, done}, 0);
        check(fault_mask === '0 && fault_short === '0, "R1 result zero", 32'(fault_mask), 0);

        run(8'h00, 8'hFF, 1'b0); // R8 all on, all shorted
        run(8'hFF, 8'hFF, 1'b0); // R8 all off, all open
        run(8'hA5, 8'h00, 1'b0); // R7 healthy
        run(8'h5A, 8'h0F, 1'b0); // R7 low half faulty
        run(8'h0F, 8'h81, 1'b0); // R7 end bits, bit order
        run(8'h3C, 8'h66, 1'b1); // R2 start ignored while busy
        for (int k = 0; k < 36; k++) begin
            run(NB'($urandom), NB'($urandom), 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule